// File: doc/BRIEF.md
# Descriptor-Driven Asynchronous Serial Receiver

This block receives asynchronous serial characters and stores them into a small on-chip character memory, steered by a table of receive buffer descriptors. Each descriptor holds a start address, a maximum length, and four flags: empty, wrap, interrupt and continuous. It also records a received count and a three-bit status once the buffer is closed. Software fills the table through a write port. It reads back descriptors and memory words through two combinational read ports.

The line is oversampled at sixteen samples per bit and each bit is taken at its middle. The frame format is programmable: 5 to 14 data bits sent least significant bit first, parity that is none, even or odd, and one or two stop bits. A buffer closes when it is full, or when a programmable number of idle character times has passed since its last character. The block then moves on to the next descriptor and can pulse an interrupt. An all-zero frame is treated as a break. Breaks are not stored; their length is reported instead.

Top module: `dsc_uart_rx`

## Requirements
- R1: After reset, `irq`, `busy` and `brk_vld` are 0, and every descriptor reads back with empty 0, count 0 and status 0.
- R2: While `en` is 0 the receiver stores nothing. Once `en` is 1 it waits in hunt mode for a falling edge before it takes any character.
- R3: A low pulse shorter than half a bit time is rejected as noise and produces no character.
- R4: A character of `cfg_len` bits (5 to 14) is received least significant bit first. It is followed by 1 stop bit, or by 2 stop bits when `cfg_two_stop` is 1. The character is stored right-aligned in the memory word at the descriptor base plus its index within the buffer.
- R5: `cfg_par` selects the parity check: 0 none, 1 even, 2 odd. A parity bit that does not match sets status bit 0 of the buffer that holds the character.
- R6: A stop bit sampled low sets status bit 1, and the character is still stored.
- R7: A frame in which every sample is low, start bit through the last stop bit, is a break. It is not stored. When the line returns high, `brk_vld` pulses and `brk_len` gives the number of consecutive low bit times, start bit included.
- R8: When the stored count reaches the descriptor's maximum length, the buffer closes. The count and status are written back, the empty flag is cleared, and `irq` pulses for one cycle with `irq_idx` set to that descriptor.
- R9: After a close, reception continues in the next descriptor. That is index 0 when the wrap flag is set or the last index was used, and the next index otherwise.
- R10: A character that arrives while the current descriptor's empty flag is 0 is dropped. `busy` is then set and stays set until `en` goes to 0.
- R11: When the continuous flag is set, a close leaves the empty flag at 1, and the next pass writes again from the descriptor base.
- R12: When `cfg_max_idle` is non-zero and a buffer holds data, the buffer closes after that many idle character times with status bit 2 set. Every new start bit restarts the count, and a value of 0 disables the timer.
- R13: A close on a descriptor whose interrupt flag is 0 produces no `irq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Receiver enable |
| os_tick | input | 1 | Strobe at 16 times the baud rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 4 | Data bits per character, 5..14 |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_max_idle | input | IDLE_W | Idle character times before close, 0 disables |
| bdw_en | input | 1 | Descriptor write strobe |
| bdw_idx | input | $clog2(NDESC) | Descriptor index to write |
| bdw_empty | input | 1 | Empty flag to write |
| bdw_wrap | input | 1 | Wrap flag to write |
| bdw_intr | input | 1 | Interrupt flag to write |
| bdw_cont | input | 1 | Continuous flag to write |
| bdw_maxlen | input | LEN_W | Maximum characters in the buffer |
| bdw_base | input | $clog2(MEM_DEPTH) | Buffer start address |
| bdr_idx | input | $clog2(NDESC) | Descriptor index to read |
| bdr_empty | output | 1 | Empty flag of the read descriptor |
| bdr_count | output | LEN_W | Received count of the read descriptor |
| bdr_stat | output | 3 | Status: bit 0 parity, bit 1 framing, bit 2 idle close |
| mem_raddr | input | $clog2(MEM_DEPTH) | Character memory read address |
| mem_rdata | output | 14 | Character memory read data |
| irq | output | 1 | One-cycle pulse on an interrupting close |
| irq_idx | output | $clog2(NDESC) | Descriptor that was closed |
| busy | output | 1 | Sticky flag: a character was dropped |
| brk_vld | output | 1 | One-cycle pulse at the end of a break |
| brk_len | output | 8 | Break length in bit times |

## Verification
The bench builds the block with NDESC=4, MEM_DEPTH=64, LEN_W=8 and IDLE_W=16, and ties `os_tick` high so that a bit lasts 16 clocks. With these values it can sweep all sixty frame formats (ten lengths, three parity modes, two stop settings), each with a two-character buffer and, where parity is on, a deliberately wrong parity bit. With four descriptors and short buffers, chaining, wrap, busy drops and continuous overwrite each take only a few characters. With a 10-bit frame, an idle character is 160 clocks, so the idle timeout can be measured on both sides of its deadline.

// File: rtl/dsc_uart_rx_pkg.sv
package dsc_uart_rx_pkg;

    localparam int MAX_BITS = 14;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } par_mode_e;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRK
    } rx_state_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                perr;
        logic                ferr;
    } rx_char_t;

    // bit 2 idle close, bit 1 framing, bit 0 parity
    typedef struct packed {
        logic idle;
        logic ferr;
        logic perr;
    } bd_stat_t;

    // number of bit times in one frame: start + data + parity + stops
    function automatic logic [4:0] frame_bits(input logic [3:0] len,
                                              input par_mode_e pm,
                                              input logic two);
        return 5'd1 + 5'(len) + ((pm != PAR_NONE) ? 5'd1 : 5'd0)
               + (two ? 5'd2 : 5'd1);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff <= RST_VAL;
                else     ff <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff <= {STAGES{RST_VAL}};
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import dsc_uart_rx_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  logic      rx,
    input  logic [3:0] cfg_len,
    input  par_mode_e cfg_par,
    input  logic      cfg_two,
    output rx_char_t  chr,
    output logic      chr_vld,
    output logic      start_seen,
    output logic      idle_char,
    output logic      brk_vld,
    output logic [7:0] brk_len
);
    localparam int CW  = $clog2(OS);
    localparam int TKW = 5 + CW;

    rx_state_e           st;
    logic [CW-1:0]       cnt;
    logic [3:0]          bitn;
    logic                stopn;
    logic [MAX_BITS-1:0] sh;
    logic                pbit, lowall, ferr;
    logic [TKW-1:0]      itk;
    logic [4:0]          fbits;
    logic [TKW-1:0]      ftk;
    logic                mid, full, perr_c, nxt_low, nxt_ferr;

    assign fbits    = frame_bits(cfg_len, cfg_par, cfg_two);
    assign ftk      = TKW'(fbits) << CW;
    assign mid      = (cnt == CW'(OS/2 - 1));
    assign full     = (cnt == CW'(OS - 1));
    assign nxt_low  = lowall & ~rx;
    assign nxt_ferr = ferr | ~rx;

    always_comb begin
        unique case (cfg_par)
            PAR_EVEN: perr_c = pbit != (^sh);
            PAR_ODD:  perr_c = pbit != ~(^sh);
            default:  perr_c = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st <= RX_HUNT; cnt <= '0; bitn <= '0; stopn <= 1'b0; sh <= '0;
            pbit <= 1'b0; lowall <= 1'b0; ferr <= 1'b0; itk <= '0;
            chr <= '0; chr_vld <= 1'b0; start_seen <= 1'b0;
            idle_char <= 1'b0; brk_vld <= 1'b0; brk_len <= '0;
        end else begin
            chr_vld    <= 1'b0;
            start_seen <= 1'b0;
            idle_char  <= 1'b0;
            brk_vld    <= 1'b0;
            if (tick) begin
                unique case (st)
                    RX_HUNT: begin
                        if (!rx) begin
                            st <= RX_START; cnt <= '0; itk <= '0;
                        end else if (itk == ftk - 1'b1) begin
                            itk <= '0; idle_char <= 1'b1;
                        end else begin
                            itk <= itk + 1'b1;
                        end
                    end
                    RX_START: begin
                        if (mid) begin
                            if (rx) st <= RX_HUNT;
                            else begin
                                st <= RX_DATA; cnt <= '0; bitn <= '0; sh <= '0;
                                lowall <= 1'b1; ferr <= 1'b0; pbit <= 1'b0;
                                stopn <= 1'b0; start_seen <= 1'b1;
                            end
                        end else cnt <= cnt + 1'b1;
                    end
                    RX_DATA: begin
                        if (full) begin
                            cnt <= '0; sh[bitn] <= rx; lowall <= nxt_low;
                            bitn <= bitn + 1'b1;
                            if (bitn == cfg_len - 4'd1)
                                st <= (cfg_par != PAR_NONE) ? RX_PAR : RX_STOP;
                        end else cnt <= cnt + 1'b1;
                    end
                    RX_PAR: begin
                        if (full) begin
                            cnt <= '0; pbit <= rx; lowall <= nxt_low; st <= RX_STOP;
                        end else cnt <= cnt + 1'b1;
                    end
                    RX_STOP: begin
                        if (full) begin
                            cnt <= '0;
                            if (cfg_two && !stopn) begin
                                stopn <= 1'b1; lowall <= nxt_low; ferr <= nxt_ferr;
                            end else begin
                                itk <= '0;
                                if (nxt_low) begin
                                    st <= RX_BRK; brk_len <= 8'(fbits);
                                end else begin
                                    st <= RX_HUNT; chr_vld <= 1'b1;
                                    chr <= '{data: sh, perr: perr_c, ferr: nxt_ferr};
                                end
                            end
                        end else cnt <= cnt + 1'b1;
                    end
                    RX_BRK: begin
                        if (full) begin
                            cnt <= '0;
                            if (!rx) brk_len <= brk_len + 1'b1;
                            else begin brk_vld <= 1'b1; st <= RX_HUNT; end
                        end else cnt <= cnt + 1'b1;
                    end
                    default: st <= RX_HUNT;
                endcase
            end
        end
    end

    // R4
    bitn_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st == RX_DATA) |-> (bitn < cfg_len));
    // R4
    char_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        chr_vld |-> ($past(st) == RX_STOP));
    // R3
    noise_reject_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(st) == RX_START && st == RX_HUNT) |-> $past(rx));
    // R7
    brk_min_len_chk: assert property (@(posedge clk) disable iff (rst)
        brk_vld |-> (brk_len >= 8'd7));
endmodule

// File: rtl/rx_bd_ctrl.sv
module rx_bd_ctrl
    import dsc_uart_rx_pkg::*;
#(
    parameter int NDESC     = 4,
    parameter int MEM_DEPTH = 64,
    parameter int LEN_W     = 8,
    parameter int IDLE_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  rx_char_t                     chr,
    input  logic                         chr_vld,
    input  logic                         start_seen,
    input  logic                         idle_char,
    input  logic [IDLE_W-1:0]            max_idle,
    input  logic                         bdw_en,
    input  logic [$clog2(NDESC)-1:0]     bdw_idx,
    input  logic                         bdw_empty,
    input  logic                         bdw_wrap,
    input  logic                         bdw_intr,
    input  logic                         bdw_cont,
    input  logic [LEN_W-1:0]             bdw_maxlen,
    input  logic [$clog2(MEM_DEPTH)-1:0] bdw_base,
    input  logic [$clog2(NDESC)-1:0]     bdr_idx,
    output logic                         bdr_empty,
    output logic [LEN_W-1:0]             bdr_count,
    output logic [2:0]                   bdr_stat,
    input  logic [$clog2(MEM_DEPTH)-1:0] mem_raddr,
    output logic [MAX_BITS-1:0]          mem_rdata,
    output logic                         irq,
    output logic [$clog2(NDESC)-1:0]     irq_idx,
    output logic                         busy
);
    localparam int AW = $clog2(MEM_DEPTH);
    localparam int IW = $clog2(NDESC);

    typedef struct packed {
        logic             empty;
        logic             wrap;
        logic             intr;
        logic             cont;
        logic [LEN_W-1:0] maxlen;
        logic [LEN_W-1:0] count;
        logic [AW-1:0]    base;
        bd_stat_t         st;
    } bd_t;

    bd_t                 bd [NDESC];
    logic [MAX_BITS-1:0] mem [MEM_DEPTH];
    logic [IW-1:0]       cur;
    logic [LEN_W-1:0]    fill;
    bd_stat_t            acc;
    logic                armed;
    logic [IDLE_W-1:0]   icnt;

    bd_t              cur_bd;
    logic             take, close_full, close_idle, do_close;
    logic [LEN_W-1:0] fill_n, cnt_out;
    bd_stat_t         st_out;
    logic [IW-1:0]    nxt;
    logic [AW-1:0]    wptr;

    always_comb begin
        cur_bd     = bd[cur];
        take       = en && chr_vld && cur_bd.empty;
        fill_n     = fill + 1'b1;
        close_full = take && (fill_n >= cur_bd.maxlen);
        close_idle = en && !chr_vld && armed && (max_idle != '0) && (icnt >= max_idle);
        do_close   = close_full || close_idle;
        cnt_out    = close_full ? fill_n : fill;
        st_out     = acc;
        if (close_full) begin
            st_out.perr = acc.perr | chr.perr;
            st_out.ferr = acc.ferr | chr.ferr;
        end else begin
            st_out.idle = 1'b1;
        end
        nxt  = (cur_bd.wrap || cur == IW'(NDESC - 1)) ? '0 : cur + 1'b1;
        wptr = cur_bd.base + AW'(fill);
    end

    always_ff @(posedge clk) begin
        if (take) mem[wptr] <= chr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NDESC; i++) bd[i] <= '0;
            cur <= '0; fill <= '0; acc <= '0; armed <= 1'b0; icnt <= '0;
            irq <= 1'b0; irq_idx <= '0; busy <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (bdw_en)
                bd[bdw_idx] <= '{empty: bdw_empty, wrap: bdw_wrap, intr: bdw_intr,
                                 cont: bdw_cont, maxlen: bdw_maxlen, count: '0,
                                 base: bdw_base, st: '0};
            if (!en) begin
                cur <= '0; fill <= '0; acc <= '0; armed <= 1'b0;
                icnt <= '0; busy <= 1'b0;
            end else begin
                if (start_seen)
                    icnt <= '0;
                else if (idle_char && armed && max_idle != '0)
                    icnt <= icnt + 1'b1;
                if (chr_vld && !cur_bd.empty)
                    busy <= 1'b1;
                if (take) begin
                    fill     <= fill_n;
                    acc.perr <= acc.perr | chr.perr;
                    acc.ferr <= acc.ferr | chr.ferr;
                    armed    <= 1'b1;
                end
                if (do_close) begin
                    bd[cur].count <= cnt_out;
                    bd[cur].st    <= st_out;
                    if (!cur_bd.cont) bd[cur].empty <= 1'b0;
                    irq     <= cur_bd.intr;
                    irq_idx <= cur;
                    cur     <= nxt;
                    fill    <= '0;
                    acc     <= '0;
                    armed   <= 1'b0;
                    icnt    <= '0;
                end
            end
        end
    end

    assign bdr_empty = bd[bdr_idx].empty;
    assign bdr_count = bd[bdr_idx].count;
    assign bdr_stat  = bd[bdr_idx].st;
    assign mem_rdata = mem[mem_raddr];

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(chr_vld));
    // R9
    cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(chr_vld) && !$past(armed)) |-> $stable(cur));
    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(chr_vld) || $past(armed)));
    // R12
    armed_fill_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (fill != '0));
endmodule

// File: rtl/dsc_uart_rx.sv
module dsc_uart_rx
    import dsc_uart_rx_pkg::*;
#(
    parameter int NDESC     = 4,
    parameter int MEM_DEPTH = 64,
    parameter int LEN_W     = 8,
    parameter int IDLE_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic                         os_tick,
    input  logic                         rxd,
    input  logic [3:0]                   cfg_len,
    input  logic [1:0]                   cfg_par,
    input  logic                         cfg_two_stop,
    input  logic [IDLE_W-1:0]            cfg_max_idle,
    input  logic                         bdw_en,
    input  logic [$clog2(NDESC)-1:0]     bdw_idx,
    input  logic                         bdw_empty,
    input  logic                         bdw_wrap,
    input  logic                         bdw_intr,
    input  logic                         bdw_cont,
    input  logic [LEN_W-1:0]             bdw_maxlen,
    input  logic [$clog2(MEM_DEPTH)-1:0] bdw_base,
    input  logic [$clog2(NDESC)-1:0]     bdr_idx,
    output logic                         bdr_empty,
    output logic [LEN_W-1:0]             bdr_count,
    output logic [2:0]                   bdr_stat,
    input  logic [$clog2(MEM_DEPTH)-1:0] mem_raddr,
    output logic [13:0]                  mem_rdata,
    output logic                         irq,
    output logic [$clog2(NDESC)-1:0]     irq_idx,
    output logic                         busy,
    output logic                         brk_vld,
    output logic [7:0]                   brk_len
);
    logic     rx_s;
    rx_char_t chr;
    logic     chr_vld, start_seen, idle_char;

    rx_line_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
    );

    rx_frame_engine #(.OS(16)) u_eng (
        .clk(clk), .rst(rst), .en(en), .tick(os_tick), .rx(rx_s),
        .cfg_len(cfg_len), .cfg_par(par_mode_e'(cfg_par)), .cfg_two(cfg_two_stop),
        .chr(chr), .chr_vld(chr_vld), .start_seen(start_seen),
        .idle_char(idle_char), .brk_vld(brk_vld), .brk_len(brk_len)
    );

    rx_bd_ctrl #(.NDESC(NDESC), .MEM_DEPTH(MEM_DEPTH), .LEN_W(LEN_W),
                 .IDLE_W(IDLE_W)) u_bd (
        .clk(clk), .rst(rst), .en(en), .chr(chr), .chr_vld(chr_vld),
        .start_seen(start_seen), .idle_char(idle_char), .max_idle(cfg_max_idle),
        .bdw_en(bdw_en), .bdw_idx(bdw_idx), .bdw_empty(bdw_empty),
        .bdw_wrap(bdw_wrap), .bdw_intr(bdw_intr), .bdw_cont(bdw_cont),
        .bdw_maxlen(bdw_maxlen), .bdw_base(bdw_base), .bdr_idx(bdr_idx),
        .bdr_empty(bdr_empty), .bdr_count(bdr_count), .bdr_stat(bdr_stat),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .irq(irq),
        .irq_idx(irq_idx), .busy(busy)
    );
endmodule

// File: tb/sim_dsc_uart_rx.sv
module sim_dsc_uart_rx;
    logic        clk = 1'b0, rst = 1'b1, en = 1'b0, rxd = 1'b1;
    logic [3:0]  cfg_len = 4'd8;
    logic [1:0]  cfg_par = 2'd0;
    logic        cfg_two_stop = 1'b0;
    logic [15:0] cfg_max_idle = '0;
    logic        bdw_en = 1'b0, bdw_empty = 1'b0, bdw_wrap = 1'b0;
    logic        bdw_intr = 1'b0, bdw_cont = 1'b0;
    logic [1:0]  bdw_idx = '0, bdr_idx = '0, irq_idx;
    logic [7:0]  bdw_maxlen = '0, bdr_count, brk_len;
    logic [5:0]  bdw_base = '0, mem_raddr = '0;
    logic        bdr_empty, irq, busy, brk_vld;
    logic [2:0]  bdr_stat;
    logic [13:0] mem_rdata;

    int checks = 0, errors = 0, irq_n = 0, last_irq = 0, brk_n = 0, last_brk = 0;

    always #4 clk = ~clk;

    dsc_uart_rx u0 (
        .clk(clk), .rst(rst), .en(en), .os_tick(1'b1), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
        .cfg_max_idle(cfg_max_idle), .bdw_en(bdw_en), .bdw_idx(bdw_idx),
        .bdw_empty(bdw_empty), .bdw_wrap(bdw_wrap), .bdw_intr(bdw_intr),
        .bdw_cont(bdw_cont), .bdw_maxlen(bdw_maxlen), .bdw_base(bdw_base),
        .bdr_idx(bdr_idx), .bdr_empty(bdr_empty), .bdr_count(bdr_count),
        .bdr_stat(bdr_stat), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .irq(irq), .irq_idx(irq_idx), .busy(busy), .brk_vld(brk_vld),
        .brk_len(brk_len)
    );

    always @(negedge clk) begin
        if (irq)     begin irq_n++; last_irq = int'(irq_idx); end
        if (brk_vld) begin brk_n++; last_brk = int'(brk_len); end
    end

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_time(input logic b);
        rxd = b;
        wait_clk(16);
    endtask

    task automatic frame(input int d, input bit bad_par = 0, input bit bad_stop = 0);
        int  m = (1 << cfg_len) - 1;
        bit  p;
        bit_time(1'b0);
        for (int i = 0; i < int'(cfg_len); i++) bit_time(1'((d >> i) & 1));
        if (cfg_par != 2'd0) begin
            p = ^(d & m);
            if (cfg_par == 2'd2) p = ~p;
            bit_time(p ^ bad_par);
        end
        bit_time(~bad_stop);
        if (cfg_two_stop) bit_time(1'b1);
        rxd = 1'b1;
        wait_clk(3);
    endtask

    task automatic bd_write(input int idx, input bit e, input bit w, input bit i,
                            input bit c, input int ml, input int base);
        @(negedge clk);
        bdw_idx = 2'(idx); bdw_empty = e; bdw_wrap = w; bdw_intr = i;
        bdw_cont = c; bdw_maxlen = 8'(ml); bdw_base = 6'(base); bdw_en = 1'b1;
        @(negedge clk);
        bdw_en = 1'b0;
    endtask

    task automatic bd_read(input int idx, output int e, output int c, output int s);
        bdr_idx = 2'(idx);
        #1;
        e = int'(bdr_empty); c = int'(bdr_count); s = int'(bdr_stat);
    endtask

    task automatic mem_read(input int a, output int d);
        mem_raddr = 6'(a);
        #1;
        d = int'(mem_rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int e, c, s, d, n0, ci, m, d0, d1, base;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        check("R1 irq", int'(irq), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 brk_vld", int'(brk_vld), 0);
        for (int k = 0; k < 4; k++) begin
            bd_read(k, e, c, s);
            check("R1 empty", e, 0); check("R1 count", c, 0); check("R1 stat", s, 0);
        end

        // R2 nothing stored while disabled, hunt after enable
        bd_write(0, 1, 1, 1, 0, 1, 5);
        frame(32'h55);
        bd_read(0, e, c, s);
        check("R2 empty while disabled", e, 1);
        check("R2 no irq while disabled", irq_n, 0);
        en = 1'b1; wait_clk(5);
        frame(32'h2A);
        mem_read(5, d); check("R2 first char after enable", d, 32'h2A);
        bd_read(0, e, c, s); check("R2 count", c, 1); check("R2 closed", e, 0);

        // R3 short low pulse is noise
        bd_write(0, 1, 1, 1, 0, 2, 10);
        rxd = 1'b0; wait_clk(5); rxd = 1'b1; wait_clk(40);
        frame(32'h33);
        bd_read(0, e, c, s); check("R3 glitch not counted", e, 1);
        frame(32'h44);
        bd_read(0, e, c, s); check("R3 count", c, 2);
        mem_read(10, d); check("R3 data0", d, 32'h33);
        mem_read(11, d); check("R3 data1", d, 32'h44);

        // R4 R5 R8 sweep of every frame format
        ci = 0;
        for (int cl = 5; cl <= 14; cl++)
            for (int pm = 0; pm < 3; pm++)
                for (int tw = 0; tw < 2; tw++) begin
                    cfg_len = 4'(cl); cfg_par = 2'(pm); cfg_two_stop = 1'(tw);
                    m = (1 << cl) - 1;
                    d0 = (ci * 29 + 3) & m;
                    d1 = (ci * 53 + (m >> 1)) & m;
                    base = (ci * 2) % 62;
                    bd_write(0, 1, 1, 1, 0, 2, base);
                    n0 = irq_n;
                    frame(d0); frame(d1);
                    bd_read(0, e, c, s);
                    check("R8 sweep closed", e, 0);
                    check("R8 sweep count", c, 2);
                    check("R5 sweep clean status", s, 0);
                    check("R8 sweep irq", irq_n, n0 + 1);
                    mem_read(base, d);     check("R4 sweep data0", d, d0);
                    mem_read(base + 1, d); check("R4 sweep data1", d, d1);
                    if (pm != 0) begin
                        bd_write(0, 1, 1, 1, 0, 1, 63);
                        frame(d1, 1);
                        bd_read(0, e, c, s); check("R5 wrong parity flagged", s, 1);
                        mem_read(63, d); check("R5 char kept", d, d1);
                    end
                    ci++;
                end

        cfg_len = 4'd8; cfg_par = 2'd0; cfg_two_stop = 1'b0;

        // R9 chaining into next descriptor, R8 irq index
        bd_write(0, 1, 0, 1, 0, 2, 20);
        bd_write(1, 1, 1, 1, 0, 3, 30);
        frame(32'h01); frame(32'h02); frame(32'h03); frame(32'h04);
        bd_read(0, e, c, s); check("R9 first closed", e, 0); check("R9 first count", c, 2);
        bd_read(1, e, c, s); check("R9 second still open", e, 1);
        mem_read(30, d); check("R9 overflow data0", d, 3);
        mem_read(31, d); check("R9 overflow data1", d, 4);
        frame(32'h05);
        bd_read(1, e, c, s); check("R9 second closed", e, 0); check("R9 second count", c, 3);
        check("R8 irq_idx", last_irq, 1);

        // R10 busy on a non-empty descriptor (wrap returned to index 0)
        n0 = irq_n;
        frame(32'h66);
        check("R10 busy set", int'(busy), 1);
        check("R10 no irq on drop", irq_n, n0);
        mem_read(20, d); check("R10 old data intact", d, 1);
        en = 1'b0; wait_clk(2);
        check("R10 busy cleared by disable", int'(busy), 0);
        en = 1'b1; wait_clk(2);

        // R11 continuous mode
        bd_write(0, 1, 1, 1, 1, 1, 40);
        n0 = irq_n;
        frame(32'hA1);
        bd_read(0, e, c, s); check("R11 stays empty", e, 1); check("R11 count", c, 1);
        check("R11 irq", irq_n, n0 + 1);
        frame(32'hB2);
        mem_read(40, d); check("R11 overwritten", d, 32'hB2);
        check("R11 second irq", irq_n, n0 + 2);

        // R13 no interrupt flag
        bd_write(0, 1, 1, 0, 0, 1, 41);
        n0 = irq_n;
        frame(32'h77);
        bd_read(0, e, c, s); check("R13 closed", e, 0);
        check("R13 no irq", irq_n, n0);

        // R6 framing error
        bd_write(0, 1, 1, 1, 0, 1, 43);
        frame(32'h5A, 0, 1);
        wait_clk(20);
        bd_read(0, e, c, s); check("R6 framing status", s, 2); check("R6 count", c, 1);
        mem_read(43, d); check("R6 char kept", d, 32'h5A);

        // R7 break of 30 bit times, 8 data bits with even parity
        cfg_par = 2'd1;
        bd_write(0, 1, 1, 1, 0, 1, 44);
        n0 = brk_n;
        rxd = 1'b0; wait_clk(30 * 16); rxd = 1'b1; wait_clk(40);
        check("R7 break pulse", brk_n, n0 + 1);
        check("R7 break length", last_brk, 30);
        bd_read(0, e, c, s); check("R7 break not stored", e, 1);
        frame(32'h11);
        mem_read(44, d); check("R7 recovery data", d, 32'h11);
        bd_read(0, e, c, s); check("R7 recovery status", s, 0);
        cfg_par = 2'd0;

        // R12 idle timeout: 10-bit frame gives 160 clocks per idle char
        cfg_max_idle = 16'd3;
        bd_write(0, 1, 1, 1, 0, 8, 50);
        frame(32'h21); frame(32'h22); frame(32'h23);
        wait_clk(320);
        bd_read(0, e, c, s); check("R12 open before timeout", e, 1);
        wait_clk(320);
        bd_read(0, e, c, s);
        check("R12 closed on idle", e, 0); check("R12 count", c, 3);
        check("R12 idle status", s, 4);
        bd_write(0, 1, 1, 1, 0, 8, 54);
        frame(32'h31); wait_clk(400); frame(32'h32); wait_clk(400);
        bd_read(0, e, c, s); check("R12 restarted by start bit", e, 1);
        wait_clk(200);
        bd_read(0, e, c, s); check("R12 closed after restart", e, 0);
        check("R12 restart count", c, 2);
        cfg_max_idle = 16'd0;
        bd_write(0, 1, 1, 1, 0, 8, 58);
        frame(32'h41); wait_clk(1000);
        bd_read(0, e, c, s); check("R12 zero disables timer", e, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule